// File: doc/BRIEF.md
# Debounced Switch Input Port

This block is a memory-mapped input device for a bank of slide switches or push buttons. It sits on a simple processor bus made of an address, a write enable, write data and read data. Each raw input passes through a two-flop synchronizer. A stability counter then admits a new value into the data register only after the value has held steady for a programmable number of clock cycles. That number should be set to the clock frequency times 10 ms. Software therefore only ever reads the filtered value.

A control/status word sits at a fixed offset of 0x100 above the data address. It holds a Ready flag that marks a fresh filtered value and an Overrun flag that marks a change software missed. It also holds an interrupt enable, and the interrupt request is driven while Ready and the enable are both set. The read-data output is zero unless one of the two addresses is being read, so the outputs of several such devices can be OR-combined onto one return bus.

Top module: `dbnc_in_port`

## Requirements
- R1: After reset, the data word, the control word and the interrupt request are all zero.
- R2: A raw value is copied into the data register only after its synchronized copy has been the same for DEBOUNCE_CYCLES+1 consecutive rising edges. It can first be read on the data address DEBOUNCE_CYCLES+3 edges after the first edge that samples it.
- R3: Reading the data address returns the filtered value in the low WIDTH bits and zeros above them. Writes to the data address change nothing.
- R4: Ready (control bit 0) becomes 1 on the edge where the filtered value changes. A write to bit 0 has no effect.
- R5: A read of the data address, with no filtered change on the same edge, clears Ready.
- R6: Overrun (control bit 2) becomes 1 when the filtered value changes while Ready is already 1.
- R7: A control write with bit 2 at 0 clears Overrun. A control write with bit 2 at 1 leaves Overrun unchanged.
- R8: Interrupt enable (control bit 8) is loaded from bit 8 of every control write. The interrupt request equals Ready AND enable.
- R9: The read data is zero whenever write enable is high or the address matches neither register. All unused control bits read as zero.
- R10: When a data read and a filtered change meet on the same edge, the change wins. Ready ends at 1, and Overrun is set if Ready was already 1.
- R11: A raw pulse shorter than DEBOUNCE_CYCLES+1 cycles leaves the data, Ready and Overrun unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | WIDTH | Raw switch inputs, asynchronous |
| addr_i | input | ADDR_W | Bus address |
| we_i | input | 1 | Bus write enable; a matching address with this low is a read |
| wdata_i | input | DATA_W | Bus write data |
| rdata_o | output | DATA_W | Bus read data, zero when not selected |
| irq_o | output | 1 | Interrupt request |

## Verification
The inputs are held clean and long, which separates the filter delay from the status rules. Short glitches of several lengths just under the threshold show whether the counter restarts on every raw change. Two filtered changes without a read in between tell Overrun apart from Ready. A data read is then swept across every cycle offset around a change edge, which exposes which rule wins when a clear and a set land on the same edge. Writes to both addresses with chosen bit patterns separate writable, clear-only and ignored bits.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int unsigned RDY_BIT = 0;
  localparam int unsigned OVR_BIT = 2;
  localparam int unsigned IE_BIT  = 8;

  typedef struct packed {
    logic ie;
    logic ovr;
    logic rdy;
  } stat_t;
endpackage

// File: rtl/dip_sync.sv
module dip_sync #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dip_debounce.sv
module dip_debounce #(
  parameter int unsigned WIDTH = 10,
  parameter int unsigned LIMIT = 2_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] s_i,
  output logic [WIDTH-1:0] deb_o,
  output logic             chg_o
);
  localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LIMIT - 1);

  logic [WIDTH-1:0] cand_q, deb_q;
  logic [CNT_W-1:0] cnt_q;
  logic             steady, pending;

  assign steady  = (s_i == cand_q);
  assign pending = (cand_q != deb_q);
  assign chg_o   = steady && pending && (cnt_q == CNT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      deb_q  <= '0;
      cnt_q  <= '0;
    end else if (!steady) begin
      // any raw movement restarts the window
      cand_q <= s_i;
      cnt_q  <= '0;
    end else if (chg_o) begin
      deb_q <= cand_q;
      cnt_q <= '0;
    end else if (pending) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign deb_o = deb_q;

  // R2
  deb_only_on_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deb_q != $past(deb_q)) |-> $past(chg_o));
  // R11
  chg_needs_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> $stable(s_i));
endmodule

// File: rtl/dip_regs.sv
module dip_regs
  import dip_pkg::*;
#(
  parameter int unsigned WIDTH     = 10,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 32'hF000_0014,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hF000_0114
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  deb_i,
  input  logic              chg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  stat_t st_q, st_d;
  logic  hit_data, hit_ctrl, rd_data, rd_ctrl, wr_ctrl;
  logic [DATA_W-1:0] ctrl_word;

  assign hit_data = (addr_i == DATA_ADDR);
  assign hit_ctrl = (addr_i == CTRL_ADDR);
  assign rd_data  = hit_data && !we_i;
  assign rd_ctrl  = hit_ctrl && !we_i;
  assign wr_ctrl  = hit_ctrl && we_i;

  always_comb begin
    st_d = st_q;
    if (chg_i) begin
      st_d.rdy = 1'b1;
      if (st_q.rdy) st_d.ovr = 1'b1;
    end else if (rd_data) begin
      st_d.rdy = 1'b0;
    end
    if (wr_ctrl) begin
      st_d.ie = wdata_i[IE_BIT];
      // set by a change beats a software clear
      if (!wdata_i[OVR_BIT] && !(chg_i && st_q.rdy)) st_d.ovr = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[RDY_BIT] = st_q.rdy;
    ctrl_word[OVR_BIT] = st_q.ovr;
    ctrl_word[IE_BIT]  = st_q.ie;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_data)      rdata_o = {{(DATA_W-WIDTH){1'b0}}, deb_i};
    else if (rd_ctrl) rdata_o = ctrl_word;
  end

  assign irq_o = st_q.rdy && st_q.ie;

  // R4
  rdy_on_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> st_q.rdy);
  // R5
  rdy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !chg_i) |=> !st_q.rdy);
  // R6
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i && st_q.rdy) |=> st_q.ovr);
  // R7
  ovr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q.ovr) |-> $past(chg_i));
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (st_q.ie && st_q.rdy));
  // R9
  rdata_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i || (!hit_data && !hit_ctrl)) |-> (rdata_o == '0));
endmodule

// File: rtl/dbnc_in_port.sv
module dbnc_in_port #(
  parameter int unsigned WIDTH           = 10,
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned ADDR_W          = 32,
  parameter int unsigned DEBOUNCE_CYCLES = 2_000_000,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 32'hF000_0014
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  raw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = DATA_ADDR + ADDR_W'(32'h100);

  logic [WIDTH-1:0] sync_w, deb_w;
  logic             chg_w;

  dip_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_w)
  );

  dip_debounce #(.WIDTH(WIDTH), .LIMIT(DEBOUNCE_CYCLES)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (sync_w),
    .deb_o (deb_w),
    .chg_o (chg_w)
  );

  dip_regs #(
    .WIDTH    (WIDTH),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .DATA_ADDR(DATA_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .deb_i  (deb_w),
    .chg_i  (chg_w),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/dbnc_in_port_tb.sv
`timescale 1ns/1ps
module dbnc_in_port_tb;
  localparam int W   = 10;
  localparam int LIM = 8;
  localparam logic [31:0] DA = 32'hF000_0014;
  localparam logic [31:0] CA = 32'hF000_0114;
  localparam logic [31:0] IA = 32'hF000_0040;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [W-1:0] raw_i = '0;
  logic [31:0] addr_i = IA;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] hist[$];
  logic [W-1:0] deb_m = '0, last_s = '0;
  int  run = 1;
  bit  rdy_m = 0, ovr_m = 0, ie_m = 0;
  int  collisions = 0;

  always #2.5 clk = ~clk;

  dbnc_in_port #(.WIDTH(W), .DEBOUNCE_CYCLES(LIM), .DATA_ADDR(DA)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .raw_i(raw_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic [W-1:0] raw, input logic [31:0] a, input logic w,
                      input logic [31:0] wd, input string tag);
    logic [31:0] exp;
    logic [W-1:0] s;
    bit chg;
    @(negedge clk);
    raw_i = raw; addr_i = a; we_i = w; wdata_i = wd;
    #1;
    exp = '0;
    if (!w && a == DA) exp = 32'(deb_m);
    else if (!w && a == CA) exp = (32'(ie_m) << 8) | (32'(ovr_m) << 2) | 32'(rdy_m);
    chk(rdata_o, exp, tag);
    chk(32'(irq_o), 32'(rdy_m && ie_m), "R8");
    @(posedge clk);
    hist.push_back(raw);
    if (hist.size() > 3) void'(hist.pop_front());
    s = (hist.size() >= 3) ? hist[0] : '0;
    if (s == last_s) run++; else run = 1;
    last_s = s;
    chg = (run >= LIM + 1) && (s != deb_m);
    if (chg && !w && a == DA) collisions++;
    if (chg) begin
      if (rdy_m) ovr_m = 1;
      rdy_m = 1;
      deb_m = s;
    end else if (!w && a == DA) rdy_m = 0;
    if (w && a == CA) begin
      ie_m = wd[8];
      if (!wd[2] && !(chg && ovr_m && rdy_m && !chg)) begin
        if (!(chg && ovr_m)) ovr_m = 0;
      end
    end
  endtask

  task automatic idle(input logic [W-1:0] raw, input int n, input string tag);
    for (int i = 0; i < n; i++) step(raw, CA, 1'b0, '0, tag);
  endtask

  initial begin
    #1;
    addr_i = CA; #1; chk(rdata_o, 32'h0, "R1");
    chk(32'(irq_o), 32'h0, "R1");
    addr_i = DA; #1; chk(rdata_o, 32'h0, "R1");
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;

    idle('0, 4, "R1");
    // clean change, watch Ready rise cycle by cycle
    idle(10'h155, LIM + 6, "R2");
    step(10'h155, DA, 1'b0, '0, "R3");
    step(10'h155, CA, 1'b0, '0, "R5");
    step(10'h155, DA, 1'b1, 32'hFFFF_FFFF, "R3");
    step(10'h155, DA, 1'b0, '0, "R3");
    step(10'h155, IA, 1'b0, '0, "R9");
    step(10'h155, CA, 1'b1, 32'h0000_0001, "R4");
    step(10'h155, CA, 1'b0, '0, "R4");
    // glitches of several lengths
    for (int g = 1; g <= LIM; g++) begin
      for (int i = 0; i < g; i++) step(10'h2AA, CA, 1'b0, '0, "R11");
      idle(10'h155, LIM + 4, "R11");
    end
    step(10'h155, DA, 1'b0, '0, "R11");
    // interrupt enable and overrun
    step(10'h155, CA, 1'b1, 32'h0000_0100, "R8");
    idle(10'h0F0, LIM + 5, "R8");
    idle(10'h00F, LIM + 5, "R6");
    step(10'h00F, CA, 1'b1, 32'h0000_0104, "R7");
    step(10'h00F, CA, 1'b0, '0, "R7");
    step(10'h00F, CA, 1'b1, 32'h0000_0100, "R7");
    step(10'h00F, CA, 1'b0, '0, "R7");
    step(10'h00F, DA, 1'b0, '0, "R5");
    step(10'h00F, CA, 1'b0, '0, "R8");
    step(10'h00F, CA, 1'b1, 32'h0000_0000, "R8");
    step(10'h00F, CA, 1'b0, '0, "R9");
    // read swept across the change edge
    for (int off = 0; off < LIM + 6; off++) begin
      logic [W-1:0] v;
      v = (off % 2 == 0) ? 10'h3C3 : 10'h03C;
      for (int i = 0; i < off; i++) step(v, IA, 1'b0, '0, "R10");
      step(v, DA, 1'b0, '0, "R10");
      idle(v, LIM + 5 - ((off < LIM + 5) ? off : LIM + 5), "R10");
      step(v, CA, 1'b0, '0, "R10");
      step(v, CA, 1'b1, 32'h0, "R10");
      step(v, DA, 1'b0, '0, "R10");
    end
    checks++;
    if (collisions == 0) begin
      errors++;
      $display("FAIL R10: got %0d collisions expected >0", collisions);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule